// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits next to a small CPU. It chooses which interrupt the CPU takes next, and when it takes it. It watches N maskable request lines and one non-maskable request. It issues a one-cycle take strobe together with a vector number. The CPU pulses a return input when a handler finishes. Stacking, vector fetch and the pipeline are left to the CPU.

One maskable line, picked by an index input, runs at the high level. That line can preempt a handler that is running at the normal level. Among the normal lines the block uses one of two orderings: a fixed ordering in which the lowest index wins, or a rotating ordering in which the line serviced last drops to the back. A three-bit status output shows which levels have a handler running. The global enable is a plain input, and the block never changes it. Request lines are level-held, and each source clears its own flag. A compact vector mode folds all vectors into three.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, take_o is 0 and status_o is 000.
- R2: A request on nmi_i is taken with vector 0 whenever status_o[2] is clear. gie_i has no effect on it, and it outranks every maskable line.
- R3: The line whose index equals hi_sel_i is at the high level. In normal vector mode its vector is index+1. When gie_i is 1 it is taken while status_o[2:1] is 00, even if a normal-level handler is running (status_o[0]=1).
- R4: With rr_en_i=0, the pending normal line with the lowest index is taken, with vector index+1. This holds again after a return while the same requests are still held.
- R5: With rr_en_i=1, the search starts at the index just after the normal line taken last, wrapping at N_IRQ. After reset the search starts at index 0.
- R6: No maskable take occurs while gie_i=0. No take occurs while a handler of the same or a higher level is running, and this includes the time an NMI handler is running.
- R7: A take sets status bit 2 for NMI, bit 1 for the high level, or bit 0 for the normal level. A reti_i pulse clears only the highest set bit. status_o changes only on a take or a return.
- R8: With compact_i=1, the vector is 0 for NMI, 1 for the high-level line, and 2 for any other line.
- R9: take_o rises on the first clock edge at which the take condition holds. It lasts one cycle for each take. A request that is still held after its return is taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_IRQ | Level-held maskable requests |
| nmi_i | input | 1 | Non-maskable request |
| gie_i | input | 1 | Global enable for the maskable requests |
| hi_sel_i | input | IW | Index of the high-level line |
| rr_en_i | input | 1 | 1 selects rotating order for the normal lines |
| compact_i | input | 1 | 1 selects the three-vector mapping |
| reti_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | Take strobe |
| vec_o | output | VW | Vector number, valid while take_o is high |
| status_o | output | 3 | Running handlers: bit 2 NMI, bit 1 high level, bit 0 normal level |

## Verification
The bench targets preemption. A high-level line raised during a normal-level handler must be taken at once, while the same line raised during an NMI handler must wait for that handler's return. A controller that ignored either level would take too early or never. Return pulses are applied with two status bits set, so a design that cleared the lowest bit, or cleared every bit, shows the wrong status. The same two held requests are run in both orderings: a fixed-order design repeats one vector, and a broken rotation never reaches the second line. Compact-mode vectors and a request held while gie_i is low are also checked; a wrong mapping or an ignored gie_i shows up as an unexpected or wrong take.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ST_LO  = 0;
  localparam int ST_HI  = 1;
  localparam int ST_NMI = 2;

  typedef enum logic [1:0] {
    LVL_NONE,
    LVL_LO,
    LVL_HI,
    LVL_NMI
  } lvl_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic          rr_i,
  input  logic [IW-1:0] last_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    int base;
    found_o = 1'b0;
    idx_o   = '0;
    base    = rr_i ? int'(last_i) + 1 : 0;
    if (base >= N) base = 0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = base + k;
      if (j >= N) j = j - N;
      if (!found_o && req_i[j]) begin
        found_o = 1'b1;
        idx_o   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/irq_status.sv
module irq_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] set_i,
  input  logic       ret_i,
  output logic [2:0] status_o
);
  logic [2:0] st_q, clr;

  // return retires the highest running level only
  always_comb begin
    clr = 3'b000;
    if (ret_i) begin
      if      (st_q[2]) clr = 3'b100;
      else if (st_q[1]) clr = 3'b010;
      else if (st_q[0]) clr = 3'b001;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= 3'b000;
    else         st_q <= (st_q & ~clr) | set_i;
  end

  assign status_o = st_q;
endmodule

// File: rtl/irq_vec.sv
module irq_vec import irq_pkg::*; #(
  parameter int IW = 3,
  parameter int VW = 4
) (
  input  lvl_e          lvl_i,
  input  logic [IW-1:0] idx_i,
  input  logic          compact_i,
  output logic [VW-1:0] vec_o
);
  logic [VW-1:0] full;
  assign full = VW'(idx_i) + VW'(1);

  always_comb begin
    unique case (lvl_i)
      LVL_HI:  vec_o = compact_i ? VW'(1) : full;
      LVL_LO:  vec_o = compact_i ? VW'(2) : full;
      default: vec_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl import irq_pkg::*; #(
  parameter  int N_IRQ = 8,
  localparam int IW    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int VW    = $clog2(N_IRQ + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             nmi_i,
  input  logic             gie_i,
  input  logic [IW-1:0]    hi_sel_i,
  input  logic             rr_en_i,
  input  logic             compact_i,
  input  logic             reti_i,
  output logic             take_o,
  output logic [VW-1:0]    vec_o,
  output logic [2:0]       status_o
);
  logic [N_IRQ-1:0] hi_mask, lo_req;
  logic             hi_req, lo_found;
  logic [IW-1:0]    lo_idx, last_q, cand_idx;
  logic [2:0]       st, set_mask;
  lvl_e             cand;
  logic [VW-1:0]    cand_vec, vec_q;
  logic             take_q;

  always_comb begin
    hi_mask = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (IW'(i) == hi_sel_i) hi_mask[i] = 1'b1;
  end

  assign lo_req = irq_i & ~hi_mask;
  assign hi_req = |(irq_i & hi_mask);

  irq_pick #(.N(N_IRQ), .IW(IW)) u_pick (
    .req_i   (lo_req),
    .rr_i    (rr_en_i),
    .last_i  (last_q),
    .found_o (lo_found),
    .idx_o   (lo_idx)
  );

  // a take needs every equal or higher level idle
  always_comb begin
    cand     = LVL_NONE;
    cand_idx = lo_idx;
    set_mask = 3'b000;
    if (nmi_i && !st[ST_NMI]) begin
      cand = LVL_NMI;
      set_mask[ST_NMI] = 1'b1;
    end else if (gie_i && hi_req && st[ST_NMI:ST_HI] == 2'b00) begin
      cand     = LVL_HI;
      cand_idx = hi_sel_i;
      set_mask[ST_HI] = 1'b1;
    end else if (gie_i && lo_found && st == 3'b000) begin
      cand = LVL_LO;
      set_mask[ST_LO] = 1'b1;
    end
  end

  irq_vec #(.IW(IW), .VW(VW)) u_vec (
    .lvl_i     (cand),
    .idx_i     (cand_idx),
    .compact_i (compact_i),
    .vec_o     (cand_vec)
  );

  irq_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_mask),
    .ret_i    (reti_i),
    .status_o (st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      vec_q  <= '0;
      last_q <= IW'(N_IRQ - 1);
    end else begin
      take_q <= (cand != LVL_NONE);
      if (cand != LVL_NONE) vec_q <= cand_vec;
      if (cand == LVL_LO) last_q <= lo_idx;
    end
  end

  assign take_o   = take_q;
  assign vec_o    = vec_q;
  assign status_o = st;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter  int N_IRQ = 8,
  localparam int VW    = $clog2(N_IRQ + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          nmi_i,
  input logic          gie_i,
  input logic          reti_i,
  input logic          take_o,
  input logic [VW-1:0] vec_o,
  input logic [2:0]    status_o
);
  AST_NO_TAKE_IN_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !$past(status_o[2])); // R6
  AST_MASKED_BY_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !$past(nmi_i)) |-> $past(gie_i)); // R6
  AST_PREEMPT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(status_o[0])) |-> ($rose(status_o[1]) || $rose(status_o[2]))); // R3
  AST_NMI_SET_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> take_o); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_o && !$past(reti_i)) |-> $stable(status_o)); // R7
  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (int'(vec_o) <= N_IRQ)); // R8
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          nmi = 1'b0, gie = 1'b0, rr = 1'b0, cmp = 1'b0, reti = 1'b0;
  logic [IW-1:0] hi_sel = 3'd7;
  logic          take;
  logic [VW-1:0] vec;
  logic [2:0]    status;

  int tests = 0, fails = 0;
  int exp_q[$];
  string exp_tag[$];

  always #2 clk = ~clk;

  irq_ctrl #(.N_IRQ(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi), .gie_i(gie),
    .hi_sel_i(hi_sel), .rr_en_i(rr), .compact_i(cmp), .reti_i(reti),
    .take_o(take), .vec_o(vec), .status_o(status)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_take(string tag, int v);
    exp_q.push_back(v);
    exp_tag.push_back(tag);
  endtask

  // monitor: every take must match the oldest expected vector
  always @(negedge clk) begin
    if (rst_n && take) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL unexpected take (R6): actual vec %0d expected none", vec);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(t, int'(vec), e);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reti();
    reti = 1'b1;
    step(1);
    reti = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(2);
    chk("R1 take after reset", int'(take), 0);
    chk("R1 status after reset", int'(status), 0);
    rst_n = 1'b1;
    step(1);

    // R6: gie low blocks maskable
    irq = 8'b0000_0001;
    step(3);
    chk("R6 no take with gie low", int'(take), 0);
    chk("R6 status with gie low", int'(status), 0);
    gie = 1'b1;
    expect_take("R6 take after gie set", 1);
    step(1);
    irq = '0;
    do_reti();
    chk("R7 status after single reti", int'(status), 0);

    // R4 fixed order, lowest index
    irq = 8'b0010_1100;
    expect_take("R4 lowest index", 3);
    step(1);
    chk("R7 status lo set", int'(status), 1);
    irq = '0;
    do_reti();

    // R2 NMI ignores gie; R6 NMI blocks high level
    gie = 1'b0; nmi = 1'b1;
    expect_take("R2 nmi vector", 0);
    step(1);
    chk("R2 status nmi", int'(status), 4);
    nmi = 1'b0; gie = 1'b1; hi_sel = 3'd5; irq = 8'b0010_0000;
    step(3);
    chk("R6 hi held during nmi", int'(status), 4);
    expect_take("R3 hi after nmi return", 6);
    do_reti();
    chk("R7 nmi cleared", int'(status), 0);
    step(1);
    chk("R3 status hi", int'(status), 2);
    irq = '0;
    do_reti();

    // R3 preemption of normal handler, R7 highest-first return
    irq = 8'b0000_0010;
    expect_take("R4 normal line 1", 2);
    step(1);
    irq = 8'b0010_0010;
    expect_take("R3 preempt vector", 6);
    step(1);
    chk("R3 status both", int'(status), 3);
    irq = '0;
    do_reti();
    chk("R7 reti clears hi first", int'(status), 1);
    do_reti();
    chk("R7 reti clears lo", int'(status), 0);

    // R4/R9 fixed order repeats the same line
    hi_sel = 3'd7; irq = 8'b0000_1010;
    expect_take("R4 first of two", 2);
    step(1);
    expect_take("R9 held request retaken fixed", 2);
    do_reti();
    step(1);
    irq = '0;
    do_reti();

    // R5 rotation
    do_reset();
    rr = 1'b1; irq = 8'b0000_1010;
    expect_take("R5 first after reset", 2);
    step(1);
    expect_take("R5 rotate to line 3", 4);
    do_reti();
    step(1);
    expect_take("R5 wrap to line 1", 2);
    do_reti();
    step(1);
    irq = '0;
    do_reti();
    rr = 1'b0;

    // R8 compact vectors
    cmp = 1'b1; hi_sel = 3'd4;
    irq = 8'b0100_0000;
    expect_take("R8 compact normal", 2);
    step(1);
    irq = 8'b0101_0000;
    expect_take("R8 compact hi", 1);
    step(1);
    nmi = 1'b1;
    expect_take("R8 compact nmi", 0);
    step(1);
    chk("R7 all levels", int'(status), 7);
    nmi = 1'b0; irq = '0;
    do_reti();
    chk("R7 step 1", int'(status), 3);
    do_reti();
    chk("R7 step 2", int'(status), 1);
    do_reti();
    chk("R7 step 3", int'(status), 0);

    step(3);
    chk("R9 pending expectations", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule